// File: doc/BRIEF.md
# Circular Fault Event Queue Writer

This block takes fault event descriptions and stores them as fixed 32-byte records in a circular queue that lives in system memory. The queue size is a power of two, and the block holds the producer index itself. A separate agent reads records and moves the consumer index forward. The block receives that consumer index as an input and uses it to decide whether the queue is full or empty at the moment an event is taken.

When an event lands in a queue that held nothing, the block can notify software. If interrupts are enabled, it does one of two things. It sends a message-signalled interrupt (MSI) write when that capability is present and a non-zero target address is set. Otherwise it pulses a wired interrupt line for one cycle. If an event arrives while the queue is full, no memory write is made. Instead a sticky fatal overflow flag is set.

Top module: `evtq_writer`

## Requirements
- R1: After reset, `prod_idx` is 0, `overflow` is 0, `evt_ready` is 1, and `mem_wr_valid`, `msi_valid` and `irq_pulse` are 0.
- R2: The size mask is (1 << `cfg_log2size`) − 1. An event is accepted when `evt_valid` and `evt_ready` are both 1. If at acceptance ((`prod_idx` + 1) & mask) equals (`cons_idx` & mask), the event is consumed and nothing else happens: no record write, no notification, and `prod_idx` does not change. `overflow` rises in that case and stays 1 until reset.
- R3: The record write address is `cfg_base` + (`prod_idx` & mask) × 32.
- R4: The record occupies 256 bits, little-endian by 64-bit word:
  - bits [SID_W-1:0] hold the stream ID;
  - bits [32 +: SSID_W] hold the substream ID;
  - bit 64 is 1 for a read and 0 for a write;
  - bits [128 +: ADDR_W] hold the faulting address;
  - every other bit is 0.
- R5: `prod_idx` changes only in the cycle after a record write handshake (`mem_wr_valid` and `mem_wr_ready` both 1). It then becomes (old + 1) & mask.
- R6: `evt_ready` is 0 from the cycle after an event is accepted into a non-full queue until every write for that event has been accepted.
- R7: A notification is sent only when `cfg_irq_en` is 1 and the queue is empty at acceptance, meaning (`prod_idx` & mask) equals (`cons_idx` & mask). Any other accepted event produces neither an MSI write nor an interrupt pulse.
- R8: When a notification is due, and at acceptance `cfg_msi_cap` is 1 and `cfg_msi_addr` is non-zero:
  - after the record write is accepted, one MSI write is issued;
  - its address and data are the `cfg_msi_addr` and `cfg_msi_data` values sampled at acceptance;
  - `irq_pulse` is not asserted.
- R9: When a notification is due and the MSI condition does not hold, `irq_pulse` is 1 for exactly one cycle, the cycle after the record write handshake. No MSI write is issued.
- R10: While `mem_wr_valid` or `msi_valid` is waiting for ready, it stays 1 and its address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event request present |
| evt_ready | output | 1 | Block can take an event |
| evt_sid | input | SID_W | Stream ID of the faulting transaction |
| evt_ssid | input | SSID_W | Substream ID |
| evt_is_write | input | 1 | 1 when the faulting access was a write |
| evt_addr | input | ADDR_W | Faulting input address |
| cfg_base | input | ADDR_W | Queue base address in memory |
| cfg_log2size | input | L2_W | Log2 of the queue entry count (0..MAX_LOG2) |
| cons_idx | input | MAX_LOG2 | Consumer index |
| cfg_irq_en | input | 1 | Notification enable |
| cfg_msi_cap | input | 1 | MSI capability present |
| cfg_msi_addr | input | ADDR_W | MSI target address |
| cfg_msi_data | input | MSI_DW | MSI payload |
| mem_wr_valid | output | 1 | Record write request |
| mem_wr_ready | input | 1 | Memory accepts the record write |
| mem_wr_addr | output | ADDR_W | Record write address |
| mem_wr_data | output | 256 | Record contents |
| prod_idx | output | MAX_LOG2 | Producer index |
| overflow | output | 1 | Sticky fatal queue-full flag |
| msi_valid | output | 1 | MSI write request |
| msi_ready | input | 1 | MSI write accepted |
| msi_addr | output | ADDR_W | MSI write address |
| msi_data | output | MSI_DW | MSI write payload |
| irq_pulse | output | 1 | One-cycle wired interrupt |

## Verification
The in-design properties check several handshake rules on every cycle:
- the producer index moves only on a record handshake, and by exactly one slot under the mask;
- requests hold steady while stalled;
- the event port is closed while a write is outstanding;
- a full queue never starts a write;
- the overflow flag is sticky;
- the wired pulse lasts a single cycle.

Other behaviours depend on the whole queue state at acceptance, and only the bench scenarios show them:
- which events notify;
- whether the MSI path or the wired path is taken;
- the exact record address and layout;
- where the one reserved slot sits across wrap-around.

The bench sweeps every queue size from 2 to 8 entries against every enable and MSI combination.

// File: rtl/evtq_pkg.sv
package evtq_pkg;

    // Record geometry: four 64-bit words.
    localparam int unsigned REC_BYTES = 32;
    localparam int unsigned WORD_BITS = 64;
    localparam int unsigned REC_BITS  = REC_BYTES * 8;
    localparam int unsigned REC_WORDS = REC_BITS / WORD_BITS;
    localparam int unsigned REC_SHIFT = $clog2(REC_BYTES);

    // Word positions inside a record.
    localparam int unsigned W_IDS  = 0;
    localparam int unsigned W_DIR  = 1;
    localparam int unsigned W_ADDR = 2;

    // Bit offset of the substream ID inside the ID word.
    localparam int unsigned SSID_LSB = 32;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REC  = 2'd1,
        ST_MSI  = 2'd2
    } wr_state_e;

endpackage

// File: rtl/evtq_ring_math.sv
module evtq_ring_math #(
    parameter int unsigned IDX_W = 8,
    parameter int unsigned L2_W  = 4
) (
    input  logic [IDX_W-1:0] prod,
    input  logic [IDX_W-1:0] cons,
    input  logic [L2_W-1:0]  log2size,
    output logic [IDX_W-1:0] mask,
    output logic [IDX_W-1:0] prod_next,
    output logic             full,
    output logic             empty
);

    logic [IDX_W-1:0] prod_m;
    logic [IDX_W-1:0] cons_m;

    always_comb begin
        for (int i = 0; i < int'(IDX_W); i++) begin
            mask[i] = (i < int'(log2size));
        end
        prod_m    = prod & mask;
        cons_m    = cons & mask;
        prod_next = (prod + IDX_W'(1)) & mask;
        full      = (prod_next == cons_m);
        empty     = (prod_m == cons_m);
    end

endmodule

// File: rtl/evtq_record_pack.sv
module evtq_record_pack
    import evtq_pkg::*;
#(
    parameter int unsigned SID_W  = 16,
    parameter int unsigned SSID_W = 20,
    parameter int unsigned ADDR_W = 48
) (
    input  logic [SID_W-1:0]    sid,
    input  logic [SSID_W-1:0]   ssid,
    input  logic                is_write,
    input  logic [ADDR_W-1:0]   addr,
    output logic [REC_BITS-1:0] rec
);

    logic [WORD_BITS-1:0] words [REC_WORDS];

    always_comb begin
        for (int w = 0; w < int'(REC_WORDS); w++) begin
            words[w] = '0;
        end
        words[W_IDS][SID_W-1:0]          = sid;
        words[W_IDS][SSID_LSB +: SSID_W] = ssid;
        words[W_DIR][0]                  = ~is_write;
        words[W_ADDR][ADDR_W-1:0]        = addr;
    end

    for (genvar w = 0; w < int'(REC_WORDS); w++) begin : g_word
        assign rec[w*WORD_BITS +: WORD_BITS] = words[w];
    end

endmodule

// File: rtl/evtq_notify_sel.sv
module evtq_notify_sel #(
    parameter int unsigned ADDR_W = 48
) (
    input  logic              irq_en,
    input  logic              was_empty,
    input  logic              msi_cap,
    input  logic [ADDR_W-1:0] msi_addr,
    output logic              notify,
    output logic              use_msi
);

    always_comb begin
        notify  = irq_en & was_empty;
        use_msi = msi_cap & (|msi_addr);
    end

endmodule

// File: rtl/evtq_writer.sv
module evtq_writer
    import evtq_pkg::*;
#(
    parameter int unsigned MAX_LOG2 = 8,
    parameter int unsigned SID_W    = 16,
    parameter int unsigned SSID_W   = 20,
    parameter int unsigned ADDR_W   = 48,
    parameter int unsigned MSI_DW   = 32,
    parameter int unsigned L2_W     = $clog2(MAX_LOG2 + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                evt_valid,
    output logic                evt_ready,
    input  logic [SID_W-1:0]    evt_sid,
    input  logic [SSID_W-1:0]   evt_ssid,
    input  logic                evt_is_write,
    input  logic [ADDR_W-1:0]   evt_addr,
    input  logic [ADDR_W-1:0]   cfg_base,
    input  logic [L2_W-1:0]     cfg_log2size,
    input  logic [MAX_LOG2-1:0] cons_idx,
    input  logic                cfg_irq_en,
    input  logic                cfg_msi_cap,
    input  logic [ADDR_W-1:0]   cfg_msi_addr,
    input  logic [MSI_DW-1:0]   cfg_msi_data,
    output logic                mem_wr_valid,
    input  logic                mem_wr_ready,
    output logic [ADDR_W-1:0]   mem_wr_addr,
    output logic [REC_BITS-1:0] mem_wr_data,
    output logic [MAX_LOG2-1:0] prod_idx,
    output logic                overflow,
    output logic                msi_valid,
    input  logic                msi_ready,
    output logic [ADDR_W-1:0]   msi_addr,
    output logic [MSI_DW-1:0]   msi_data,
    output logic                irq_pulse
);

    localparam int unsigned IDX_W = MAX_LOG2;
    localparam int unsigned OFF_W = IDX_W + REC_SHIFT;

    typedef struct packed {
        wr_state_e          st;
        logic [IDX_W-1:0]   prod;
        logic               ovf;
        logic [ADDR_W-1:0]  wr_addr;
        logic [REC_BITS-1:0] rec;
        logic               notify;
        logic               use_msi;
        logic [ADDR_W-1:0]  msi_addr;
        logic [MSI_DW-1:0]  msi_data;
        logic               pulse;
    } wr_regs_t;

    wr_regs_t r_d, r_q;

    logic [IDX_W-1:0]    ring_mask;
    logic [IDX_W-1:0]    ring_next;
    logic                ring_full;
    logic                ring_empty;
    logic [REC_BITS-1:0] rec_w;
    logic                notify_w;
    logic                use_msi_w;
    logic [OFF_W-1:0]    slot_off;

    evtq_ring_math #(
        .IDX_W (IDX_W),
        .L2_W  (L2_W)
    ) u_ring (
        .prod      (r_q.prod),
        .cons      (cons_idx),
        .log2size  (cfg_log2size),
        .mask      (ring_mask),
        .prod_next (ring_next),
        .full      (ring_full),
        .empty     (ring_empty)
    );

    evtq_record_pack #(
        .SID_W  (SID_W),
        .SSID_W (SSID_W),
        .ADDR_W (ADDR_W)
    ) u_pack (
        .sid      (evt_sid),
        .ssid     (evt_ssid),
        .is_write (evt_is_write),
        .addr     (evt_addr),
        .rec      (rec_w)
    );

    evtq_notify_sel #(
        .ADDR_W (ADDR_W)
    ) u_notify (
        .irq_en    (cfg_irq_en),
        .was_empty (ring_empty),
        .msi_cap   (cfg_msi_cap),
        .msi_addr  (cfg_msi_addr),
        .notify    (notify_w),
        .use_msi   (use_msi_w)
    );

    assign slot_off = {r_q.prod & ring_mask, REC_SHIFT'(0)};

    // Next-state process
    always_comb begin
        r_d       = r_q;
        r_d.pulse = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (evt_valid) begin
                    if (ring_full) begin
                        r_d.ovf = 1'b1;
                    end else begin
                        r_d.st       = ST_REC;
                        r_d.wr_addr  = cfg_base + ADDR_W'(slot_off);
                        r_d.rec      = rec_w;
                        r_d.notify   = notify_w;
                        r_d.use_msi  = use_msi_w;
                        r_d.msi_addr = cfg_msi_addr;
                        r_d.msi_data = cfg_msi_data;
                    end
                end
            end
            ST_REC: begin
                if (mem_wr_ready) begin
                    r_d.prod = ring_next;
                    if (r_q.notify && r_q.use_msi) begin
                        r_d.st = ST_MSI;
                    end else begin
                        r_d.st    = ST_IDLE;
                        r_d.pulse = r_q.notify;
                    end
                end
            end
            ST_MSI: begin
                if (msi_ready) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    // Register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign evt_ready    = (r_q.st == ST_IDLE);
    assign mem_wr_valid = (r_q.st == ST_REC);
    assign mem_wr_addr  = r_q.wr_addr;
    assign mem_wr_data  = r_q.rec;
    assign prod_idx     = r_q.prod;
    assign overflow     = r_q.ovf;
    assign msi_valid    = (r_q.st == ST_MSI);
    assign msi_addr     = r_q.msi_addr;
    assign msi_data     = r_q.msi_data;
    assign irq_pulse    = r_q.pulse;

    // R2
    full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && evt_ready && ring_full) |=> (!mem_wr_valid && overflow));

    // R2
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    // R5
    prod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_wr_valid && mem_wr_ready) |=> $stable(prod_idx));

    // R5
    prod_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && mem_wr_ready) |=>
            (prod_idx == (($past(prod_idx) + IDX_W'(1)) & $past(ring_mask))));

    // R6
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid || msi_valid) |-> !evt_ready);

    // R9
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    // R10
    rec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_valid && !mem_wr_ready) |=> (mem_wr_valid && $stable(mem_wr_addr)));

    // R10
    msi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && !msi_ready) |=> (msi_valid && $stable(msi_addr)));

endmodule

// File: tb/sim_evtq_writer.sv
module sim_evtq_writer;

    localparam int MAX_LOG2 = 8;
    localparam int SID_W    = 16;
    localparam int SSID_W   = 20;
    localparam int ADDR_W   = 48;
    localparam int MSI_DW   = 32;
    localparam int L2_W     = 4;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic                rst_n = 1'b0;
    logic                evt_valid = 1'b0;
    logic                evt_ready;
    logic [SID_W-1:0]    evt_sid = '0;
    logic [SSID_W-1:0]   evt_ssid = '0;
    logic                evt_is_write = 1'b0;
    logic [ADDR_W-1:0]   evt_addr = '0;
    logic [ADDR_W-1:0]   cfg_base = '0;
    logic [L2_W-1:0]     cfg_log2size = '0;
    logic [MAX_LOG2-1:0] cons_idx = '0;
    logic                cfg_irq_en = 1'b0;
    logic                cfg_msi_cap = 1'b0;
    logic [ADDR_W-1:0]   cfg_msi_addr = '0;
    logic [MSI_DW-1:0]   cfg_msi_data = '0;
    logic                mem_wr_valid;
    logic                mem_wr_ready = 1'b1;
    logic [ADDR_W-1:0]   mem_wr_addr;
    logic [255:0]        mem_wr_data;
    logic [MAX_LOG2-1:0] prod_idx;
    logic                overflow;
    logic                msi_valid;
    logic                msi_ready = 1'b1;
    logic [ADDR_W-1:0]   msi_addr;
    logic [MSI_DW-1:0]   msi_data;
    logic                irq_pulse;

    evtq_writer #(
        .MAX_LOG2 (MAX_LOG2),
        .SID_W    (SID_W),
        .SSID_W   (SSID_W),
        .ADDR_W   (ADDR_W),
        .MSI_DW   (MSI_DW),
        .L2_W     (L2_W)
    ) u0 (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_valid    (evt_valid),
        .evt_ready    (evt_ready),
        .evt_sid      (evt_sid),
        .evt_ssid     (evt_ssid),
        .evt_is_write (evt_is_write),
        .evt_addr     (evt_addr),
        .cfg_base     (cfg_base),
        .cfg_log2size (cfg_log2size),
        .cons_idx     (cons_idx),
        .cfg_irq_en   (cfg_irq_en),
        .cfg_msi_cap  (cfg_msi_cap),
        .cfg_msi_addr (cfg_msi_addr),
        .cfg_msi_data (cfg_msi_data),
        .mem_wr_valid (mem_wr_valid),
        .mem_wr_ready (mem_wr_ready),
        .mem_wr_addr  (mem_wr_addr),
        .mem_wr_data  (mem_wr_data),
        .prod_idx     (prod_idx),
        .overflow     (overflow),
        .msi_valid    (msi_valid),
        .msi_ready    (msi_ready),
        .msi_addr     (msi_addr),
        .msi_data     (msi_data),
        .irq_pulse    (irq_pulse)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int n_wr = 0, n_msi = 0, n_irq = 0;
    int wr_stall = 0, msi_stall = 0;
    logic [ADDR_W-1:0] last_wr_addr = '0;
    logic [255:0]      last_wr_data = '0;
    logic [ADDR_W-1:0] last_msi_addr = '0;
    logic [MSI_DW-1:0] last_msi_data = '0;
    bit done = 1'b0;

    // Ready drivers and handshake monitor, all at the falling edge.
    always @(negedge clk) begin
        mem_wr_ready = (wr_stall == 0);
        if (mem_wr_valid && wr_stall > 0) wr_stall--;
        msi_ready = (msi_stall == 0);
        if (msi_valid && msi_stall > 0) msi_stall--;
        if (rst_n) begin
            if (mem_wr_valid && mem_wr_ready) begin
                n_wr++;
                last_wr_addr = mem_wr_addr;
                last_wr_data = mem_wr_data;
            end
            if (msi_valid && msi_ready) begin
                n_msi++;
                last_msi_addr = msi_addr;
                last_msi_data = msi_data;
            end
            if (irq_pulse) n_irq++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [255:0] act,
                       input logic [255:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    task automatic do_reset();
        rst_n = 1'b0;
        wr_stall = 0;
        msi_stall = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_ready();
        for (int g = 0; g < 200 && !evt_ready; g++) @(negedge clk);
    endtask

    task automatic send(input logic [SID_W-1:0] sid, input logic [SSID_W-1:0] ssid,
                        input bit wr, input logic [ADDR_W-1:0] a);
        wait_ready();
        evt_sid = sid;
        evt_ssid = ssid;
        evt_is_write = wr;
        evt_addr = a;
        evt_valid = 1'b1;
        @(negedge clk);
        evt_valid = 1'b0;
    endtask

    function automatic logic [255:0] exp_rec(input logic [SID_W-1:0] sid,
            input logic [SSID_W-1:0] ssid, input bit wr, input logic [ADDR_W-1:0] a);
        logic [255:0] r;
        r = '0;
        r[SID_W-1:0]      = sid;
        r[32 +: SSID_W]   = ssid;
        r[64]             = ~wr;
        r[128 +: ADDR_W]  = a;
        return r;
    endfunction

    int  model_prod = 0;
    bit  model_ovf  = 1'b0;

    // One event with full expectation checking against the arithmetic model.
    task automatic one_event(input int L, input bit ie, input int mm, input int k);
        int mask, w0, m0, i0;
        bit full, empty, notify, via_msi;
        logic [SID_W-1:0]  sid;
        logic [SSID_W-1:0] ssid;
        logic [ADDR_W-1:0] a;
        bit wr;
        mask    = (1 << L) - 1;
        full    = (((model_prod + 1) & mask) == (int'(cons_idx) & mask));
        empty   = ((model_prod & mask) == (int'(cons_idx) & mask));
        notify  = ie && empty && !full;
        via_msi = (mm == 2);
        sid  = SID_W'(16'h0A00 + k * 37 + L);
        ssid = SSID_W'(20'h5_0000 + k * 11);
        wr   = k[0];
        a    = ADDR_W'(48'h7F00_0000_0000) + ADDR_W'(k * 4096 + 8);
        w0 = n_wr; m0 = n_msi; i0 = n_irq;
        send(sid, ssid, wr, a);
        wait_ready();
        repeat (2) @(negedge clk);
        if (full) begin
            model_ovf = 1'b1;
            // R2: full queue, no write, index held, overflow set
            chk(n_wr == w0, "R2 no write", 256'(n_wr - w0), 0);
            chk(overflow == 1'b1, "R2 overflow", 256'(overflow), 1);
            chk(int'(prod_idx) == model_prod, "R2 prod held", 256'(prod_idx), 256'(model_prod));
            chk(n_msi == m0 && n_irq == i0, "R7 no notify on full", 256'(n_msi - m0 + n_irq - i0), 0);
        end else begin
            // R3 address, R4 layout, R5 producer step
            chk(n_wr == w0 + 1, "R5 one write", 256'(n_wr - w0), 1);
            chk(last_wr_addr == cfg_base + ADDR_W'(model_prod * 32), "R3 addr",
                256'(last_wr_addr), 256'(cfg_base + ADDR_W'(model_prod * 32)));
            chk(last_wr_data == exp_rec(sid, ssid, wr, a), "R4 record",
                last_wr_data, exp_rec(sid, ssid, wr, a));
            model_prod = (model_prod + 1) & mask;
            chk(int'(prod_idx) == model_prod, "R5 prod", 256'(prod_idx), 256'(model_prod));
            chk(overflow == model_ovf, "R2 overflow level", 256'(overflow), 256'(model_ovf));
            if (notify && via_msi) begin
                // R8
                chk(n_msi == m0 + 1 && n_irq == i0, "R8 msi count",
                    256'(n_msi - m0), 1);
                chk(last_msi_addr == cfg_msi_addr && last_msi_data == cfg_msi_data,
                    "R8 msi payload", 256'(last_msi_data), 256'(cfg_msi_data));
            end else if (notify) begin
                // R9
                chk(n_irq == i0 + 1 && n_msi == m0, "R9 wired pulse", 256'(n_irq - i0), 1);
            end else begin
                // R7
                chk(n_irq == i0 && n_msi == m0, "R7 no notify",
                    256'(n_irq - i0 + n_msi - m0), 0);
            end
        end
    endtask

    initial begin
        int k;
        do_reset();
        for (int L = 1; L <= 3; L++) begin
            for (int ie = 0; ie < 2; ie++) begin
                for (int mm = 0; mm < 3; mm++) begin
                    cfg_log2size = L2_W'(L);
                    cfg_base     = ADDR_W'(48'h0001_2340_0000) + ADDR_W'(L * 65536);
                    cfg_irq_en   = ie[0];
                    cfg_msi_cap  = (mm != 0);
                    cfg_msi_addr = (mm == 2) ? ADDR_W'(48'h0000_FEE0_1000) : '0;
                    cfg_msi_data = MSI_DW'(32'hC0DE_0000 + L * 16 + mm);
                    cons_idx     = '0;
                    do_reset();
                    model_prod = 0;
                    model_ovf  = 1'b0;
                    // R1
                    chk(prod_idx == '0 && overflow == 1'b0 && evt_ready == 1'b1 &&
                        !mem_wr_valid && !msi_valid && !irq_pulse, "R1 reset",
                        256'({prod_idx, overflow, evt_ready, mem_wr_valid, msi_valid, irq_pulse}),
                        256'(8'h0 << 5 | 5'b01000));
                    k = 0;
                    // Fill to the reserved slot, then one overflow (R2)
                    for (int e = 0; e < (1 << L); e++) begin
                        one_event(L, ie[0], mm, k);
                        k++;
                    end
                    // Drain, then refill across wrap-around
                    cons_idx = MAX_LOG2'(model_prod + 8 * L * 2);
                    for (int e = 0; e < (1 << L); e++) begin
                        one_event(L, ie[0], mm, k);
                        k++;
                    end
                end
            end
        end

        // Back-pressure: stalled record write, then stalled MSI (R6, R10, R5)
        cfg_log2size = 4'd3;
        cfg_irq_en   = 1'b1;
        cfg_msi_cap  = 1'b1;
        cfg_msi_addr = 48'h0000_FEE0_2000;
        cfg_msi_data = 32'h1234_5678;
        cons_idx     = '0;
        do_reset();
        wr_stall  = 4;
        msi_stall = 3;
        send(16'h00AA, 20'h0_0BB, 1'b1, 48'h0000_0000_9000);
        for (int c = 0; c < 3; c++) begin
            // R6
            chk(evt_ready == 1'b0, "R6 busy", 256'(evt_ready), 0);
            // R5
            chk(prod_idx == '0, "R5 held during stall", 256'(prod_idx), 0);
            // R10
            chk(mem_wr_valid == 1'b1 && mem_wr_addr == cfg_base, "R10 record held",
                256'(mem_wr_addr), 256'(cfg_base));
            @(negedge clk);
        end
        for (int g = 0; g < 20 && !msi_valid; g++) @(negedge clk);
        chk(msi_valid == 1'b1 && evt_ready == 1'b0, "R6 busy during msi", 256'(evt_ready), 0);
        @(negedge clk);
        // R10
        chk(msi_valid == 1'b1 && msi_addr == cfg_msi_addr, "R10 msi held",
            256'(msi_addr), 256'(cfg_msi_addr));
        wait_ready();
        repeat (2) @(negedge clk);
        chk(prod_idx == 8'd1, "R5 after stall", 256'(prod_idx), 1);
        chk(last_msi_data == 32'h1234_5678, "R8 msi after stall", 256'(last_msi_data),
            256'(32'h1234_5678));

        done = 1'b1;
        summary();
        $finish;
    end

endmodule